// File: doc/BRIEF.md
# Segmented 16-bit Host Bus Controller

This block sits between a narrow 16-bit multiplexed host bus and a set of 64-bit internal resources: a comparand word, two mask words and a memory port. The host drives an active-low enable, an active-low write strobe and an active-low command select. The block decodes each bus access into one of four cycle types from the write and command-select levels seen when enable falls. Data cycles move one 16-bit segment of a 64-bit word. A destination counter and a source counter pick the segment, and each counter advances when the enable is released.

Command writes configure the routing. They can pick a persistent data source and a persistent data destination, each held until it is replaced. They can also arm a one-shot override that sends the next single command access to the control, segment-control, address or next-free-address register. Any other command word goes out unchanged to the downstream instruction decoder. When a comparand or mask word has received its last segment, the block emits a compare pulse. It also emits one on a control-register write and on an explicit compare command. All host inputs are asynchronous and pass through a multi-stage synchronizer on the system clock.

Top module: `seg_host_bus`

## Requirements
- R1: During and after a synchronous active-high reset, the following hold until the first host cycle:
  - `host_dq_oe`, `compare_pulse`, `instr_strobe` and `mem_wr_en` are 0.
  - The comparand, mask and control words are 0.
  - Both segment counters are 0 and both terminal fields are 3.
- R2: The cycle type is taken from {write_n, cmd_n} at the enable falling edge: 00 = command write, 01 = data write, 10 = command read, 11 = data read. A command write is handled as follows:
  - If no override is armed and the top nibble is not 1, 2, 3 or 4, the word is passed to `instr_word` with a one-clock `instr_strobe`.
  - Select, override and compare commands never strobe `instr_strobe`.
- R3: `host_dq_oe` rises only as a result of a read cycle's falling enable. It returns to 0 once the enable is released. It stays 0 during write cycles.
- R4: With no selection made, data writes and data reads use the comparand. A command read with no override armed returns `status_in`.
- R5: Command 0x1 with low bits t selects the persistent data source. Command 0x2 with low bits t selects the persistent data destination. The code t means 0 = comparand, 1 = mask 1, 2 = mask 2, 3 = memory. A selection stays in effect until the next select of the same kind, and other words are unchanged by writes to it.
- R6: A data write stores into segment k of the destination, where k is the destination counter value. Segment 0 is bits 15:0. The counter advances on enable release and wraps to 0 after reaching its terminal value.
- R7: A data read returns segment k of the source, where k is the source counter value. The source counter advances on release and wraps after its terminal value.
- R8: Command 0x3 with low bits t arms a one-shot override for the next command read or write only, where t means 0 = control, 1 = segment control, 2 = address, 3 = next-free address. The next-free address is read-only, so a write to it is dropped. After that one access, command reads return status again.
- R9: `compare_pulse` is a single-clock pulse. It fires in these cases:
  - On release of a data write to the comparand or a mask, when the destination counter was at its terminal value.
  - On an override write to the control register.
  - On command 0x4.
  - It never fires for memory writes.
- R10: A data write to the memory destination gives a one-clock `mem_wr_en` with the segment index and data. `mem_addr` holds the value last written to the address register.
- R11: The segment-control register layout is as follows:
  - Bits 1:0 hold the destination terminal value and bits 3:2 the source terminal value.
  - Reads also return bits 5:4 as the destination counter and bits 7:6 as the source counter.
  - Writing this register clears both counters. A source select clears the source counter and a destination select clears the destination counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| host_en_n | input | 1 | Host enable, active low, asynchronous |
| host_wr_n | input | 1 | Host write strobe, active low |
| host_cmd_n | input | 1 | Host command select, active low |
| host_dq_in | input | 16 | Host bus input data |
| host_dq_out | output | 16 | Host bus read data |
| host_dq_oe | output | 1 | Drive enable for host_dq_out |
| status_in | input | 16 | Status word returned on default command reads |
| nfree_in | input | 9 | Next-free address from the array |
| mem_rd_data | input | 64 | Memory word for data reads |
| mem_wr_en | output | 1 | One-clock memory segment write strobe |
| mem_wr_seg | output | 2 | Segment index of the memory write |
| mem_wr_data | output | 16 | Data of the memory segment write |
| mem_addr | output | 9 | Address register value |
| cmp_word | output | 64 | Comparand word |
| mask1_word | output | 64 | Mask 1 word |
| mask2_word | output | 64 | Mask 2 word |
| ctrl_word | output | 16 | Control register value |
| compare_pulse | output | 1 | One-clock compare trigger |
| instr_strobe | output | 1 | One-clock pass-through command strobe |
| instr_word | output | 16 | Pass-through command word |

## Verification
A segment counter that has slipped or failed to clear shows up on the very next data access. Read data comes back from the wrong 16-bit slice, a written word appears rotated in `cmp_word` or a mask word, or `compare_pulse` arrives one write early or late. A stuck override flag is seen on the next command read, which returns a register value instead of `status_in`. A stale persistent selection changes a word that should have stayed untouched. All of these appear at the ports within one host cycle, that is, a few clocks after the synchronizer delay.

// File: rtl/seg_host_bus_pkg.sv
package seg_host_bus_pkg;

  typedef enum logic [1:0] {
    CYC_CMD_WR = 2'b00,
    CYC_DAT_WR = 2'b01,
    CYC_CMD_RD = 2'b10,
    CYC_DAT_RD = 2'b11
  } cyc_e;

  typedef enum logic [1:0] {
    TGT_CMP  = 2'd0,
    TGT_MSK1 = 2'd1,
    TGT_MSK2 = 2'd2,
    TGT_MEM  = 2'd3
  } tgt_e;

  typedef enum logic [1:0] {
    OVR_CTRL   = 2'd0,
    OVR_SEGCTL = 2'd1,
    OVR_ADDR   = 2'd2,
    OVR_NFREE  = 2'd3
  } ovr_e;

  localparam logic [3:0] OP_SEL_SRC = 4'h1;
  localparam logic [3:0] OP_SEL_DST = 4'h2;
  localparam logic [3:0] OP_OVR     = 4'h3;
  localparam logic [3:0] OP_CMP     = 4'h4;

endpackage

// File: rtl/seg_host_bus_sync.sv
module seg_host_bus_sync #(
  parameter int          W       = 1,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk) begin
    if (rst) begin
      stg <= {STAGES{RST_VAL}};
    end else begin
      stg[0] <= d;
      for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/seg_host_bus_segcnt.sv
module seg_host_bus_segcnt #(
  parameter int SEGW = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clr,
  input  logic            step,
  input  logic [SEGW-1:0] last,
  output logic [SEGW-1:0] cnt,
  output logic            at_last
);

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (step)  cnt <= (cnt == last) ? '0 : cnt + 1'b1;
  end

  assign at_last = (cnt == last);

  assert_cnt_bound_R6: assert property (@(posedge clk) disable iff (rst)
    !$past(clr) |-> (cnt <= last));

endmodule

// File: rtl/seg_host_bus_wordbank.sv
module seg_host_bus_wordbank #(
  parameter int DW   = 16,
  parameter int WW   = 64,
  parameter int N    = 3,
  parameter int SEGW = 2,
  parameter int IW   = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic [IW-1:0]         wr_idx,
  input  logic [SEGW-1:0]       wr_seg,
  input  logic [DW-1:0]         wr_data,
  output logic [N-1:0][WW-1:0]  words
);

  for (genvar i = 0; i < N; i++) begin : g_word
    logic [WW-1:0] w;
    always_ff @(posedge clk) begin
      if (rst) w <= '0;
      else if (wr_en && (int'(wr_idx) == i)) w[wr_seg*DW +: DW] <= wr_data;
    end
    assign words[i] = w;
  end

endmodule

// File: rtl/seg_host_bus.sv
module seg_host_bus
  import seg_host_bus_pkg::*;
#(
  parameter int DW     = 16,
  parameter int WW     = 64,
  parameter int AW     = 9,
  parameter int STAGES = 2,
  parameter int SEGS   = WW / DW,
  parameter int SEGW   = $clog2(SEGS)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            host_en_n,
  input  logic            host_wr_n,
  input  logic            host_cmd_n,
  input  logic [DW-1:0]   host_dq_in,
  output logic [DW-1:0]   host_dq_out,
  output logic            host_dq_oe,
  input  logic [DW-1:0]   status_in,
  input  logic [AW-1:0]   nfree_in,
  input  logic [WW-1:0]   mem_rd_data,
  output logic            mem_wr_en,
  output logic [SEGW-1:0] mem_wr_seg,
  output logic [DW-1:0]   mem_wr_data,
  output logic [AW-1:0]   mem_addr,
  output logic [WW-1:0]   cmp_word,
  output logic [WW-1:0]   mask1_word,
  output logic [WW-1:0]   mask2_word,
  output logic [DW-1:0]   ctrl_word,
  output logic            compare_pulse,
  output logic            instr_strobe,
  output logic [DW-1:0]   instr_word
);

  localparam int          BW      = DW + 3;
  localparam logic [BW-1:0] BUS_IDLE = {3'b111, {DW{1'b0}}};
  localparam int          NREG    = 3;
  localparam logic [SEGW-1:0] LAST_RST = SEGW'(SEGS - 1);

  // ---------------- synchronizer and edge detect ----------------
  logic [BW-1:0] bus_s;
  logic          en_s, wr_s, cmd_s;
  logic [DW-1:0] dq_s;

  seg_host_bus_sync #(.W(BW), .STAGES(STAGES), .RST_VAL(BUS_IDLE)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({host_en_n, host_wr_n, host_cmd_n, host_dq_in}),
    .q   (bus_s)
  );

  assign {en_s, wr_s, cmd_s, dq_s} = bus_s;

  logic en_prev;
  always_ff @(posedge clk) begin
    if (rst) en_prev <= 1'b1;
    else     en_prev <= en_s;
  end

  logic en_fall, en_rise;
  assign en_fall = en_prev & ~en_s;
  assign en_rise = ~en_prev & en_s;

  cyc_e cyc_now;
  assign cyc_now = cyc_e'({wr_s, cmd_s});

  // ---------------- configuration state ----------------
  cyc_e            cyc_q;
  logic            live;
  tgt_e            src_sel, dst_sel;
  logic            ovr_pend;
  ovr_e            ovr_sel;
  logic [DW-1:0]   ctrl_q;
  logic [AW-1:0]   addr_q;
  logic [SEGW-1:0] dst_last, src_last;

  logic [3:0]      opcode;
  logic [1:0]      arg;
  assign opcode = dq_s[DW-1 -: 4];
  assign arg    = dq_s[1:0];

  logic cmd_wr, segctl_wr, sel_src_hit, sel_dst_hit;
  assign cmd_wr      = en_fall && (cyc_now == CYC_CMD_WR);
  assign segctl_wr   = cmd_wr && ovr_pend && (ovr_sel == OVR_SEGCTL);
  assign sel_src_hit = cmd_wr && !ovr_pend && (opcode == OP_SEL_SRC);
  assign sel_dst_hit = cmd_wr && !ovr_pend && (opcode == OP_SEL_DST);

  // ---------------- segment counters ----------------
  logic [SEGW-1:0] dst_cnt, src_cnt;
  logic            dst_at_last, src_at_last;
  logic            dst_step, src_step;

  assign dst_step = en_rise && live && (cyc_q == CYC_DAT_WR);
  assign src_step = en_rise && live && (cyc_q == CYC_DAT_RD);

  seg_host_bus_segcnt #(.SEGW(SEGW)) u_dst_cnt (
    .clk     (clk),
    .rst     (rst),
    .clr     (segctl_wr | sel_dst_hit),
    .step    (dst_step),
    .last    (dst_last),
    .cnt     (dst_cnt),
    .at_last (dst_at_last)
  );

  seg_host_bus_segcnt #(.SEGW(SEGW)) u_src_cnt (
    .clk     (clk),
    .rst     (rst),
    .clr     (segctl_wr | sel_src_hit),
    .step    (src_step),
    .last    (src_last),
    .cnt     (src_cnt),
    .at_last (src_at_last)
  );

  // ---------------- 64-bit data words ----------------
  logic [NREG-1:0][WW-1:0] words;
  logic bank_wr;
  assign bank_wr = en_fall && (cyc_now == CYC_DAT_WR) && (dst_sel != TGT_MEM);

  seg_host_bus_wordbank #(.DW(DW), .WW(WW), .N(NREG), .SEGW(SEGW), .IW(2)) u_bank (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (bank_wr),
    .wr_idx  (dst_sel),
    .wr_seg  (dst_cnt),
    .wr_data (dq_s),
    .words   (words)
  );

  assign cmp_word   = words[TGT_CMP];
  assign mask1_word = words[TGT_MSK1];
  assign mask2_word = words[TGT_MSK2];
  assign ctrl_word  = ctrl_q;
  assign mem_addr   = addr_q;

  // ---------------- read-side multiplexers ----------------
  logic [WW-1:0] src_word;
  always_comb begin
    case (src_sel)
      TGT_CMP:  src_word = words[TGT_CMP];
      TGT_MSK1: src_word = words[TGT_MSK1];
      TGT_MSK2: src_word = words[TGT_MSK2];
      default:  src_word = mem_rd_data;
    endcase
  end

  logic [DW-1:0] src_seg;
  assign src_seg = src_word[src_cnt*DW +: DW];

  logic [DW-1:0] segctl_view;
  always_comb begin
    segctl_view = '0;
    segctl_view[SEGW-1:0]        = dst_last;
    segctl_view[2*SEGW-1:SEGW]   = src_last;
    segctl_view[3*SEGW-1:2*SEGW] = dst_cnt;
    segctl_view[4*SEGW-1:3*SEGW] = src_cnt;
  end

  logic [DW-1:0] ovr_view;
  always_comb begin
    case (ovr_sel)
      OVR_CTRL:   ovr_view = ctrl_q;
      OVR_SEGCTL: ovr_view = segctl_view;
      OVR_ADDR:   ovr_view = DW'(addr_q);
      default:    ovr_view = DW'(nfree_in);
    endcase
  end

  // ---------------- cycle execution ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      cyc_q         <= CYC_DAT_RD;
      live          <= 1'b0;
      src_sel       <= TGT_CMP;
      dst_sel       <= TGT_CMP;
      ovr_pend      <= 1'b0;
      ovr_sel       <= OVR_CTRL;
      ctrl_q        <= '0;
      addr_q        <= '0;
      dst_last      <= LAST_RST;
      src_last      <= LAST_RST;
      host_dq_out   <= '0;
      host_dq_oe    <= 1'b0;
      mem_wr_en     <= 1'b0;
      mem_wr_seg    <= '0;
      mem_wr_data   <= '0;
      compare_pulse <= 1'b0;
      instr_strobe  <= 1'b0;
      instr_word    <= '0;
    end else begin
      compare_pulse <= 1'b0;
      instr_strobe  <= 1'b0;
      mem_wr_en     <= 1'b0;

      if (en_fall) begin
        cyc_q <= cyc_now;
        live  <= 1'b1;
        case (cyc_now)
          CYC_CMD_WR: begin
            if (ovr_pend) begin
              ovr_pend <= 1'b0;
              case (ovr_sel)
                OVR_CTRL: begin
                  ctrl_q        <= dq_s;
                  compare_pulse <= 1'b1;
                end
                OVR_SEGCTL: begin
                  dst_last <= dq_s[SEGW-1:0];
                  src_last <= dq_s[2*SEGW-1:SEGW];
                end
                OVR_ADDR: addr_q <= dq_s[AW-1:0];
                default: ;
              endcase
            end else begin
              case (opcode)
                OP_SEL_SRC: src_sel <= tgt_e'(arg);
                OP_SEL_DST: dst_sel <= tgt_e'(arg);
                OP_OVR: begin
                  ovr_pend <= 1'b1;
                  ovr_sel  <= ovr_e'(arg);
                end
                OP_CMP: compare_pulse <= 1'b1;
                default: begin
                  instr_strobe <= 1'b1;
                  instr_word   <= dq_s;
                end
              endcase
            end
          end
          CYC_DAT_WR: begin
            if (dst_sel == TGT_MEM) begin
              mem_wr_en   <= 1'b1;
              mem_wr_seg  <= dst_cnt;
              mem_wr_data <= dq_s;
            end
          end
          CYC_CMD_RD: begin
            host_dq_out <= ovr_pend ? ovr_view : status_in;
            host_dq_oe  <= 1'b1;
            ovr_pend    <= 1'b0;
          end
          default: begin
            host_dq_out <= src_seg;
            host_dq_oe  <= 1'b1;
          end
        endcase
      end

      if (en_rise) begin
        live       <= 1'b0;
        host_dq_oe <= 1'b0;
        if (dst_step && (dst_sel != TGT_MEM) && dst_at_last)
          compare_pulse <= 1'b1;
      end
    end
  end

  // ---------------- assertions ----------------
  assert_oe_from_fall_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(host_dq_oe) |-> $past(en_fall));

  assert_oe_released_R3: assert property (@(posedge clk) disable iff (rst)
    en_rise |=> !host_dq_oe);

  assert_cmp_single_R9: assert property (@(posedge clk) disable iff (rst)
    compare_pulse |=> !compare_pulse);

  assert_ovr_one_shot_R8: assert property (@(posedge clk) disable iff (rst)
    (ovr_pend && en_fall && !cyc_now[0]) |=> !ovr_pend);

  assert_mem_no_cmp_R10: assert property (@(posedge clk) disable iff (rst)
    $onehot0({mem_wr_en, compare_pulse, instr_strobe}));

endmodule

// File: tb/seg_host_bus_test.sv
module seg_host_bus_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        host_en_n = 1'b1, host_wr_n = 1'b1, host_cmd_n = 1'b1;
  logic [15:0] host_dq_in = '0;
  logic [15:0] host_dq_out;
  logic        host_dq_oe;
  logic [15:0] status_in = 16'hA5C3;
  logic [8:0]  nfree_in = 9'h05A;
  logic [63:0] mem_rd_data = 64'hDDDD_CCCC_BBBB_AAAA;
  logic        mem_wr_en;
  logic [1:0]  mem_wr_seg;
  logic [15:0] mem_wr_data;
  logic [8:0]  mem_addr;
  logic [63:0] cmp_word, mask1_word, mask2_word;
  logic [15:0] ctrl_word;
  logic        compare_pulse, instr_strobe;
  logic [15:0] instr_word;

  always #2 clk = ~clk;

  seg_host_bus uut (
    .clk(clk), .rst(rst), .host_en_n(host_en_n), .host_wr_n(host_wr_n),
    .host_cmd_n(host_cmd_n), .host_dq_in(host_dq_in), .host_dq_out(host_dq_out),
    .host_dq_oe(host_dq_oe), .status_in(status_in), .nfree_in(nfree_in),
    .mem_rd_data(mem_rd_data), .mem_wr_en(mem_wr_en), .mem_wr_seg(mem_wr_seg),
    .mem_wr_data(mem_wr_data), .mem_addr(mem_addr), .cmp_word(cmp_word),
    .mask1_word(mask1_word), .mask2_word(mask2_word), .ctrl_word(ctrl_word),
    .compare_pulse(compare_pulse), .instr_strobe(instr_strobe), .instr_word(instr_word)
  );

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  typedef struct {
    logic [15:0] val;
    string       tag;
  } exp_t;
  exp_t sb_q[$];

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  // monitor: counts pulses and pops expected read data
  int          cmp_cnt = 0, instr_cnt = 0, mem_cnt = 0;
  logic [15:0] last_instr = '0, last_mdata = '0;
  logic [1:0]  last_mseg = '0;
  logic        oe_prev = 1'b0;

  always @(negedge clk) begin
    if (!rst) begin
      if (compare_pulse === 1'b1) cmp_cnt++;
      if (instr_strobe === 1'b1) begin instr_cnt++; last_instr = instr_word; end
      if (mem_wr_en === 1'b1) begin mem_cnt++; last_mseg = mem_wr_seg; last_mdata = mem_wr_data; end
      if (host_dq_oe === 1'b1 && !oe_prev) begin
        if (sb_q.size() == 0) begin
          total++; bad++;
          $display("FAIL R3 unexpected read drive got=%h exp=none", host_dq_out);
        end else begin
          exp_t e;
          e = sb_q.pop_front();
          chk(e.tag, {48'h0, host_dq_out}, {48'h0, e.val});
        end
      end
      oe_prev = host_dq_oe;
    end
  end

  logic mid_oe;

  task automatic bus(input logic w, input logic c, input logic [15:0] d);
    @(negedge clk);
    host_wr_n = w; host_cmd_n = c; host_dq_in = d;
    repeat (2) @(negedge clk);
    host_en_n = 1'b0;
    repeat (6) @(negedge clk);
    mid_oe = host_dq_oe;
    host_en_n = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic cmd_wr(input logic [15:0] d); bus(1'b0, 1'b0, d); endtask
  task automatic dat_wr(input logic [15:0] d); bus(1'b0, 1'b1, d); endtask
  task automatic cmd_rd(input logic [15:0] e, input string tag);
    sb_q.push_back('{e, tag}); bus(1'b1, 1'b0, 16'h0);
  endtask
  task automatic dat_rd(input logic [15:0] e, input string tag);
    sb_q.push_back('{e, tag}); bus(1'b1, 1'b1, 16'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 oe", host_dq_oe, 0);
    chk("R1 cmp", cmp_word, 0);
    chk("R1 ctrl", ctrl_word, 0);
    chk("R1 pulses", cmp_cnt + instr_cnt + mem_cnt, 0);

    // R4/R6 default destination is comparand, segment 0 = low bits
    dat_wr(16'h1111); dat_wr(16'h2222); dat_wr(16'h3333);
    chk("R9 no compare before last seg", cmp_cnt, 0);
    dat_wr(16'h4444);
    chk("R3 oe low during write", mid_oe, 0);
    chk("R6 comparand assembled", cmp_word, 64'h4444_3333_2222_1111);
    chk("R9 compare on last seg", cmp_cnt, 1);

    // R4/R7 default source, wrap after segment 3
    dat_rd(16'h1111, "R7 seg0"); dat_rd(16'h2222, "R7 seg1");
    dat_rd(16'h3333, "R7 seg2"); dat_rd(16'h4444, "R7 seg3");
    dat_rd(16'h1111, "R7 wrap");
    chk("R3 oe driven while enable low", mid_oe, 1);
    chk("R3 oe released", host_dq_oe, 0);
    cmd_rd(16'hA5C3, "R4 default status");

    // R5 persistent destination mask 1
    cmd_wr(16'h2001);
    dat_wr(16'h5001); dat_wr(16'h5002); dat_wr(16'h5003); dat_wr(16'h5004);
    chk("R5 mask1 written", mask1_word, 64'h5004_5003_5002_5001);
    chk("R5 comparand untouched", cmp_word, 64'h4444_3333_2222_1111);
    chk("R9 mask compare", cmp_cnt, 2);

    // R5/R11 persistent source, select clears counter
    cmd_wr(16'h1001);
    dat_rd(16'h5001, "R5 src mask1 seg0"); dat_rd(16'h5002, "R5 src mask1 seg1");
    cmd_wr(16'h1000);
    dat_rd(16'h1111, "R11 source select clears counter");

    // R11 terminal values: dst_last=1 src_last=0
    cmd_wr(16'h3001); cmd_wr(16'h0001);
    dat_wr(16'hAAAA); dat_wr(16'hBBBB);
    chk("R9 compare at short terminal", cmp_cnt, 3);
    dat_wr(16'hCCCC);
    chk("R6 wrap at terminal", mask1_word, 64'h5004_5003_BBBB_CCCC);
    chk("R9 no compare mid word", cmp_cnt, 3);
    cmd_wr(16'h3001);
    cmd_rd(16'h0011, "R11 segctl readback");
    cmd_rd(16'hA5C3, "R8 override one-shot");

    // R8 control, next-free, address
    cmd_wr(16'h3000); cmd_wr(16'h00F0);
    chk("R8 control written", ctrl_word, 16'h00F0);
    chk("R9 control write compares", cmp_cnt, 4);
    cmd_wr(16'h3003); cmd_wr(16'h1234);
    cmd_rd(16'hA5C3, "R8 next-free write dropped and consumed");
    cmd_wr(16'h3003);
    cmd_rd(16'h005A, "R8 next-free read");
    cmd_wr(16'h3002); cmd_wr(16'h0123);
    chk("R10 address register", mem_addr, 9'h123);

    // R9 forced compare, R2 pass-through
    cmd_wr(16'h4000);
    chk("R9 forced compare", cmp_cnt, 5);
    cmd_wr(16'h7ABC);
    chk("R2 instr count", instr_cnt, 1);
    chk("R2 instr word", last_instr, 16'h7ABC);

    // R10 memory destination (dst_last still 1)
    cmd_wr(16'h2003);
    dat_wr(16'hBEEF);
    chk("R10 mem seg0", {last_mseg, last_mdata}, {2'd0, 16'hBEEF});
    dat_wr(16'hF00D);
    chk("R10 mem seg1", {last_mseg, last_mdata}, {2'd1, 16'hF00D});
    chk("R10 mem count", mem_cnt, 2);
    chk("R9 no compare on memory", cmp_cnt, 5);

    // R7 memory source, src_last=0 keeps segment 0
    cmd_wr(16'h1003);
    dat_rd(16'hAAAA, "R7 mem seg0");
    dat_rd(16'hAAAA, "R7 terminal 0 repeats");
    chk("R2 no strobe from selects", instr_cnt, 1);
    chk("R4 scoreboard drained", sb_q.size(), 0);

    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule